// File: doc/BRIEF.md
# PWM Channel with Shadowed Duty Updates

A single pulse-width-modulated output channel. The input clock passes through a two-stage prescaler: a linear divide-by-(L+1) stage followed by a power-of-two stage of 2^H. Each prescaler tick advances an 8-bit period counter, which wraps to zero after reaching the programmed period value P. The output level is set by two compare points on that counter: a rising point where the level goes high and a falling point where it goes low. If the two points are equal, the level stays high for the whole period.

Two write ports load the configuration. The control word holds the divider fields and the enables for pin, counter clock, inversion, open-drain drive and synchronised update. The duty word holds the two compare points and the period value. Duty-word writes go first to a pending register. By default they move to the active set only at a period boundary, so no period ever mixes old and new settings. Software can turn this synchronisation off so that writes take effect immediately.

Top module: `pwm_chan`

## Requirements
- R1: The output period, in input clock cycles, is (L+1) * 2^H * (P+1), where L is control bits 7:0, H is control bits 11:8 and P is duty bits 31:24.
- R2: The level is high while the counter runs from the rising point (duty bits 7:0) up to, but not including, the falling point (duty bits 15:8). If the rising point is above the falling point, the high window wraps across the end of the period.
- R3: When the rising point equals the falling point, the level stays high for every cycle of the period.
- R4: When pin enable (control bit 12) is clear, pin_o is 0 and pin_oe_o is 1, whatever the counter and polarity settings.
- R5: When counter clock enable (control bit 16) is clear, the counter is held at 0 and the internal level is low. Duty words written while stopped become active and are used from the first period after the enable is set.
- R6: A control write that changes invert (control bit 14) changes the pin in the first cycle after the write, without waiting for a period boundary.
- R7: With control bit 17 clear, a duty write made while running becomes active at the next counter wrap from P to 0. A write captured on the wrap edge itself governs the period that this wrap starts.
- R8: With control bit 17 set, a duty write becomes active on the clock edge that captures it, so the level follows the new points from the next cycle.
- R9: With open-drain (control bit 13) set, pin_o is always 0, and pin_oe_o is 1 only while the polarity-adjusted, pin-gated level is low.
- R10: After reset all settings are zero: pin_o is 0, pin_oe_o is 1 and the counter is stopped.
- R11: Clearing counter clock enable drops the internal level from the second cycle after the write, without finishing the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control word |
| ctrl_wdata_i | input | 32 | Control word: divider fields and enables |
| duty_we_i | input | 1 | Write strobe for the duty word |
| duty_wdata_i | input | 32 | Duty word: rising point, falling point, period |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The critical coincidence is a duty write captured on the same clock edge as the counter wrap. To provoke it, the bench locks onto a rising output edge at a known counter phase, then counts clock cycles so that the write strobe lands exactly on the wrap edge. The design passes if the very next period already has the new high time; a design that reads the stale pending value shows the old high time for one extra period. The bench also checks that a write made mid-period leaves the current high time unchanged when synchronisation is on, and shortens it at once when synchronisation is off.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DIVL_W = 8;
  localparam int unsigned DIVH_W = 4;
  localparam int unsigned CNT_W  = 8;

  // control word field positions
  localparam int unsigned DIVL_LSB   = 0;
  localparam int unsigned DIVH_LSB   = 8;
  localparam int unsigned PIN_BIT    = 12;
  localparam int unsigned OD_BIT     = 13;
  localparam int unsigned INV_BIT    = 14;
  localparam int unsigned RUN_BIT    = 16;
  localparam int unsigned NOSYNC_BIT = 17;

  // duty word field positions
  localparam int unsigned RISE_LSB = 0;
  localparam int unsigned FALL_LSB = 8;
  localparam int unsigned PER_LSB  = 24;

  typedef struct packed {
    logic [DIVL_W-1:0] div_l;
    logic [DIVH_W-1:0] div_h;
    logic              pin_en;
    logic              od_en;
    logic              inv;
    logic              clk_en;
    logic              sync_off;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] rise;
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] per;
  } duty_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned LW = 8,
  parameter int unsigned HW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [LW-1:0] div_l_i,
  input  logic [HW-1:0] div_h_i,
  output logic          tick_o
);
  localparam int unsigned HC_W = (1 << HW) - 1;

  logic [LW-1:0]   l_cnt_q;
  logic [HC_W-1:0] h_cnt_q;
  logic [HC_W-1:0] h_mask;
  logic            l_wrap, h_wrap;

  // 2^H - 1 without subtraction
  assign h_mask = ~({HC_W{1'b1}} << div_h_i);
  assign l_wrap = l_cnt_q >= div_l_i;
  assign h_wrap = h_cnt_q >= h_mask;
  assign tick_o = run_i && l_wrap && h_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_cnt_q <= '0;
      h_cnt_q <= '0;
    end else if (!run_i) begin
      l_cnt_q <= '0;
      h_cnt_q <= '0;
    end else begin
      l_cnt_q <= l_wrap ? '0 : l_cnt_q + 1'b1;
      if (l_wrap) h_cnt_q <= h_wrap ? '0 : h_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  // >= so that a period lowered mid-count still wraps
  assign at_end = cnt_q >= per_i;
  assign wrap_o = run_i && tick_i && at_end;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  duty_t wdata_i,
  input  logic  sync_off_i,
  input  logic  run_i,
  input  logic  wrap_i,
  output duty_t act_o
);
  duty_t pend_q, pend_d, act_q;
  logic  load;

  // bypass so a write on the wrap edge lands in the new period
  assign pend_d = we_i ? wdata_i : pend_q;
  assign load   = !run_i || sync_off_i || wrap_i;
  assign act_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (load) act_q <= pend_d;
    end
  end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] rise_i,
  input  logic [CW-1:0] fall_i,
  output logic          lvl_o
);
  logic in_win, lvl_q;

  always_comb begin
    if (rise_i == fall_i)     in_win = 1'b1;
    else if (rise_i < fall_i) in_win = (cnt_i >= rise_i) && (cnt_i < fall_i);
    else                      in_win = (cnt_i >= rise_i) || (cnt_i < fall_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= run_i && in_win;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [WORD_W-1:0] ctrl_wdata_i,
  input  logic              duty_we_i,
  input  logic [WORD_W-1:0] duty_wdata_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  ctrl_t            ctrl_d, ctrl_q;
  duty_t            duty_d, act;
  logic             tick, wrap, lvl, drv;
  logic [CNT_W-1:0] cnt;
  logic             unused_wbits;

  assign ctrl_d.div_l    = ctrl_wdata_i[DIVL_LSB +: DIVL_W];
  assign ctrl_d.div_h    = ctrl_wdata_i[DIVH_LSB +: DIVH_W];
  assign ctrl_d.pin_en   = ctrl_wdata_i[PIN_BIT];
  assign ctrl_d.od_en    = ctrl_wdata_i[OD_BIT];
  assign ctrl_d.inv      = ctrl_wdata_i[INV_BIT];
  assign ctrl_d.clk_en   = ctrl_wdata_i[RUN_BIT];
  assign ctrl_d.sync_off = ctrl_wdata_i[NOSYNC_BIT];

  assign duty_d.rise = duty_wdata_i[RISE_LSB +: CNT_W];
  assign duty_d.fall = duty_wdata_i[FALL_LSB +: CNT_W];
  assign duty_d.per  = duty_wdata_i[PER_LSB +: CNT_W];

  assign unused_wbits = ^{ctrl_wdata_i[INV_BIT+1], ctrl_wdata_i[WORD_W-1:NOSYNC_BIT+1],
                          duty_wdata_i[PER_LSB-1:FALL_LSB+CNT_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_d;
  end

  pwm_prescale #(.LW(DIVL_W), .HW(DIVH_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl_q.clk_en),
    .div_l_i (ctrl_q.div_l),
    .div_h_i (ctrl_q.div_h),
    .tick_o  (tick)
  );

  pwm_period_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.clk_en),
    .tick_i (tick),
    .per_i  (act.per),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_shadow u_shd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (duty_we_i),
    .wdata_i    (duty_d),
    .sync_off_i (ctrl_q.sync_off),
    .run_i      (ctrl_q.clk_en),
    .wrap_i     (wrap),
    .act_o      (act)
  );

  pwm_wave #(.CW(CNT_W)) u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.clk_en),
    .cnt_i  (cnt),
    .rise_i (act.rise),
    .fall_i (act.fall),
    .lvl_o  (lvl)
  );

  // polarity then pin gate; open-drain only ever pulls low
  assign drv      = ctrl_q.pin_en && (lvl ^ ctrl_q.inv);
  assign pin_o    = ctrl_q.od_en ? 1'b0 : drv;
  assign pin_oe_o = ctrl_q.od_en ? !drv : 1'b1;
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
  import pwm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input ctrl_t            ctrl_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wrap_i,
  input duty_t            act_i,
  input logic             lvl_i,
  input logic             pin_i,
  input logic             pin_oe_i
);
  AST_PIN_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.pin_en |-> (!pin_i && pin_oe_i)); // R4

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.clk_en |=> (cnt_i == '0 && !lvl_i)); // R5

  AST_CNT_WAITS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.clk_en && !tick_i) |=> $stable(cnt_i)); // R1

  AST_FULL_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.clk_en && act_i.rise == act_i.fall) |=> lvl_i); // R3

  AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.clk_en && !ctrl_i.sync_off && !wrap_i) |=> $stable(act_i)); // R7

  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.od_en |-> !pin_i); // R9
endmodule

bind pwm_chan pwm_chan_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_i   (ctrl_q),
  .tick_i   (tick),
  .cnt_i    (cnt),
  .wrap_i   (wrap),
  .act_i    (act),
  .lvl_i    (lvl),
  .pin_i    (pin_o),
  .pin_oe_i (pin_oe_o)
);

// File: tb/tb_pwm_chan.sv
`timescale 1ns/1ps
module tb_pwm_chan;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we = 1'b0, duty_we = 1'b0;
  logic [31:0] ctrl_wdata = '0, duty_wdata = '0;
  logic        pin_o, pin_oe_o;
  int          n_vec = 0, n_bad = 0;
  int          hi, per, cnt_s;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pwm_chan dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (ctrl_wdata),
    .duty_we_i    (duty_we),
    .duty_wdata_i (duty_wdata),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
  );

  // columns: L, H, P, rise, fall
  localparam int VEC [6][5] = '{
    '{0, 0,  9, 2, 5},
    '{2, 0,  7, 0, 3},
    '{1, 2,  4, 1, 4},
    '{0, 1,  5, 4, 1},
    '{3, 1, 15, 0, 8},
    '{0, 3,  3, 3, 0}
  };

  function automatic logic [31:0] mk_ctrl(int dl, int dh, bit pin, bit od, bit inv, bit en, bit sd);
    logic [31:0] w = '0;
    w[7:0] = 8'(dl); w[11:8] = 4'(dh);
    w[12] = pin; w[13] = od; w[14] = inv; w[16] = en; w[17] = sd;
    return w;
  endfunction

  function automatic logic [31:0] mk_duty(int r, int f, int p);
    logic [31:0] w = '0;
    w[7:0] = 8'(r); w[15:8] = 8'(f); w[31:24] = 8'(p);
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] w);
    ctrl_wdata = w; ctrl_we = 1'b1;
    @(posedge clk); @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_duty(input logic [31:0] w);
    duty_wdata = w; duty_we = 1'b1;
    @(posedge clk); @(negedge clk);
    duty_we = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev = pin_o;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (!prev && pin_o) break;
      prev = pin_o;
    end
  endtask

  // high samples and total samples of one period starting at a rise
  task automatic measure(input bit skip, output int h, output int p);
    wait_rise();
    if (skip) wait_rise();
    h = 0; p = 0;
    while (pin_o && p < 6000) begin h++; p++; @(negedge clk); end
    while (!pin_o && p < 6000) begin p++; @(negedge clk); end
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (pin_o) c++; end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all R): actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 pin_o in reset", int'(pin_o), 0);
    chk("R10 pin_oe_o in reset", int'(pin_oe_o), 1);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 pin_o after reset", int'(pin_o), 0);

    // table: R1 period, R2 high window
    for (int i = 0; i < 6; i++) begin
      int n, eh;
      n  = (VEC[i][0] + 1) << VEC[i][1];
      eh = (VEC[i][3] < VEC[i][4]) ? (VEC[i][4] - VEC[i][3])
                                   : (VEC[i][2] + 1 - VEC[i][3] + VEC[i][4]);
      wr_ctrl(mk_ctrl(VEC[i][0], VEC[i][1], 1, 0, 0, 0, 0));
      wr_duty(mk_duty(VEC[i][3], VEC[i][4], VEC[i][2]));
      wr_ctrl(mk_ctrl(VEC[i][0], VEC[i][1], 1, 0, 0, 1, 0));
      measure(1, hi, per);
      chk("R1 period", per, (VEC[i][2] + 1) * n);
      chk("R2 high time", hi, eh * n);
    end

    // R7: mid-period write deferred
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 0, 0));
    wr_duty(mk_duty(0, 5, 9));
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 1, 0));
    wait_rise(); wait_rise();
    wr_duty(mk_duty(0, 2, 9));
    hi = 1;
    while (pin_o && hi < 100) begin hi++; @(negedge clk); end
    chk("R7 current period keeps old high", hi, 5);
    measure(0, hi, per);
    chk("R7 next period uses new high", hi, 2);

    // R7: write captured on the wrap edge
    wait_rise();
    repeat (8) @(negedge clk);
    wr_duty(mk_duty(0, 7, 9));
    measure(0, hi, per);
    chk("R7 write on wrap edge governs new period", hi, 7);

    // R8: sync off, immediate
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 1, 1));
    wr_duty(mk_duty(0, 5, 9));
    wait_rise(); wait_rise();
    wr_duty(mk_duty(0, 2, 9));
    hi = 1;
    while (pin_o && hi < 100) begin hi++; @(negedge clk); end
    chk("R8 immediate high change", hi, 2);

    // R3 full duty, then R11 stop mid-period, R5 write while stopped
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 1, 0));
    wr_duty(mk_duty(4, 4, 9));
    repeat (25) @(negedge clk);
    count_high(30, cnt_s);
    chk("R3 equal points stay high", cnt_s, 30);
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 0, 0));
    @(negedge clk);
    count_high(20, cnt_s);
    chk("R11 stop drops output at once", cnt_s, 0);
    wr_duty(mk_duty(0, 3, 7));
    count_high(10, cnt_s);
    chk("R5 stopped stays low", cnt_s, 0);
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 1, 0));
    measure(1, hi, per);
    chk("R5 stopped write high", hi, 3);
    chk("R5 stopped write period", per, 8);

    // R6 invert immediate
    wr_duty(mk_duty(2, 2, 7));
    repeat (20) @(negedge clk);
    chk("R3 full duty pin", int'(pin_o), 1);
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 1, 1, 0));
    chk("R6 invert next cycle", int'(pin_o), 0);
    wr_ctrl(mk_ctrl(0, 0, 1, 0, 0, 1, 0));
    chk("R6 invert cleared next cycle", int'(pin_o), 1);

    // R9 open drain
    wr_ctrl(mk_ctrl(0, 0, 1, 1, 0, 1, 0));
    chk("R9 od high releases oe", int'(pin_oe_o), 0);
    chk("R9 od high pin_o", int'(pin_o), 0);
    wr_ctrl(mk_ctrl(0, 0, 1, 1, 1, 1, 0));
    chk("R9 od low drives oe", int'(pin_oe_o), 1);
    chk("R9 od low pin_o", int'(pin_o), 0);

    // R4 pin disabled, inverted running channel
    wr_ctrl(mk_ctrl(0, 0, 0, 0, 1, 1, 0));
    count_high(30, cnt_s);
    chk("R4 pin disabled low", cnt_s, 0);
    chk("R4 pin disabled oe", int'(pin_oe_o), 1);

    summary();
  end
endmodule